// File: doc/BRIEF.md
# Bus-Master Disk DMA Register Block

This block is the eight-byte register window that a host uses to control one bus-master disk DMA channel. The host reaches it through a byte-wide register bus with a three-bit offset, a write strobe and a combinational read path. Inside the window are a command register, a status register and a 32-bit descriptor table base pointer. The command register carries the start/stop control and the transfer direction. The status register combines a read-only activity flag, two sticky event flags that the host clears by writing a one, and two plain read/write flags that record whether each of the two attached drives can use DMA.

A separate DMA engine fetches the descriptors and moves the data. This block drives the engine's start, direction and table pointer. It takes three single-cycle event pulses back from the engine: end of table, error and transfer complete. The interrupt output follows the completion flag. Two decoded outputs tell the host driver whether a finished transfer was clean and whether a timeout that fired while the transfer is still running should be ignored.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register reads 0x00 and start_o, dir_to_mem_o, prd_base_o, irq_o, xfer_ok_o and keep_wait_o are all 0.
- R2: Offset 0 is the command register. Bit 0 drives start_o and bit 3 drives dir_to_mem_o, where 1 means device to memory. The other bits read 0.
- R3: Status bit 0 (active) is set on the clock edge of a write that takes the start bit from 0 to 1. It is cleared on the clock edge of a write that sets the start bit to 0, or when eng_stop_i pulses. Host writes to status bit 0 have no effect.
- R4: eng_err_i sets status bit 1 and eng_done_i sets status bit 2 on the clock edge at which they are sampled. Both bits survive the transfer being stopped.
- R5: Writing 1 to status bit 1 or bit 2 at offset 2 clears that bit, and writing 0 leaves it unchanged. If an engine event for the same bit arrives in the same cycle, the bit ends up set.
- R6: Status bits 5 and 6 are read/write capability flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R7: Offsets 4 to 7 hold the descriptor pointer in little-endian byte order (offset 4 is bits 7:0). Bits 1:0 always read 0. Pointer writes are ignored while status bit 0 is set.
- R8: irq_o equals status bit 2.
- R9: xfer_ok_o is 1 exactly when status bits 2:0 are 100b.
- R10: keep_wait_o is 1 exactly when status bits 0 and 2 are both set.
- R11: Offsets 1 and 3 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register byte offset |
| wr_i | input | 1 | Write strobe for the byte at addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| eng_stop_i | input | 1 | Engine reached the end of the descriptor table |
| eng_err_i | input | 1 | Engine error pulse |
| eng_done_i | input | 1 | Engine completion/interrupt pulse |
| start_o | output | 1 | Start control to the engine |
| dir_to_mem_o | output | 1 | Direction: 1 means device to memory |
| prd_base_o | output | 32 | Descriptor table base address |
| irq_o | output | 1 | Interrupt request |
| xfer_ok_o | output | 1 | Status bits 2:0 show a clean completion |
| keep_wait_o | output | 1 | Active and interrupt both set; the host should keep waiting |

## Verification
Host write-one-to-clear writes to the error and interrupt flags can arrive in the same cycle as the engine's error and completion pulses. The bench provokes this collision by raising a status write with the clear bits set in the same clock as the matching engine pulse. It then reads the status back and expects the engine event to survive (R5). The bench also issues a start-clear write in the same cycle that an event arrives. It checks that the active bit drops while the event flag is kept.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_VEN0 = 1;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_VEN1 = 3;
  localparam int unsigned OFS_PTR  = 4;

  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_DIR   = 3;

  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;
  localparam int unsigned ST_CAP0 = 5;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic start_bit_i,
  input  logic dir_bit_i,
  output logic start_o,
  output logic dir_o,
  output logic start_rise_o,
  output logic start_fall_o
);
  logic start_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (wr_i) begin
      start_q <= start_bit_i;
      dir_q   <= dir_bit_i;
    end
  end

  assign start_rise_o = wr_i & start_bit_i & ~start_q;
  assign start_fall_o = wr_i & ~start_bit_i;
  assign start_o      = start_q;
  assign dir_o        = dir_q;

  AST_START_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (start_o == $past(start_bit_i))); // R2
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg #(
  parameter int unsigned NUM_DRV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               clr_err_i,
  input  logic               clr_irq_i,
  input  logic [NUM_DRV-1:0] cap_bits_i,
  input  logic               start_rise_i,
  input  logic               start_fall_i,
  input  logic               eng_stop_i,
  input  logic               eng_err_i,
  input  logic               eng_done_i,
  output logic               act_o,
  output logic               err_o,
  output logic               irq_o,
  output logic [NUM_DRV-1:0] cap_o
);
  logic act_q, err_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (start_fall_i || eng_stop_i) act_q <= 1'b0;
      else if (start_rise_i)          act_q <= 1'b1;
      // engine event wins over a same-cycle host clear
      if (eng_err_i)                  err_q <= 1'b1;
      else if (wr_i && clr_err_i)     err_q <= 1'b0;
      if (eng_done_i)                 irq_q <= 1'b1;
      else if (wr_i && clr_irq_i)     irq_q <= 1'b0;
    end
  end

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_cap
    logic cap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cap_q <= 1'b0;
      else if (wr_i) cap_q <= cap_bits_i[d];
    end
    assign cap_o[d] = cap_q;
  end

  assign act_o = act_q;
  assign err_o = err_q;
  assign irq_o = irq_q;

  AST_STOP_DROPS_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_fall_i || eng_stop_i) |=> !act_o); // R3
  AST_ERR_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_i |=> err_o); // R4
  AST_DONE_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> irq_o); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && clr_irq_i && !eng_done_i) |=> !irq_o); // R5
  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(wr_i && clr_err_i)) |=> err_o); // R5
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int unsigned PTR_W = 32,
  localparam int unsigned PTR_BYTES = PTR_W / 8,
  localparam int unsigned SEL_W = $clog2(PTR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       wdata_i,
  input  logic             lock_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       rdata_o
);
  logic [PTR_W-1:0] ptr_q;

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
    localparam logic [7:0] MASK = (b == 0) ? 8'hFC : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ptr_q[b*8 +: 8] <= 8'h00;
      else if (wr_i && !lock_i && sel_i == SEL_W'(b))
        ptr_q[b*8 +: 8] <= wdata_i & MASK;
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = ptr_q[sel_i*8 +: 8];

  AST_PTR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(ptr_o)); // R7
  AST_PTR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o[1:0] == 2'b00); // R7
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned PTR_W   = 32,
  parameter int unsigned NUM_DRV = 2,
  localparam int unsigned PTR_BYTES = PTR_W / 8,
  localparam int unsigned ADDR_W = $clog2(OFS_PTR + PTR_BYTES),
  localparam int unsigned SEL_W  = $clog2(PTR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              eng_stop_i,
  input  logic              eng_err_i,
  input  logic              eng_done_i,
  output logic              start_o,
  output logic              dir_to_mem_o,
  output logic [PTR_W-1:0]  prd_base_o,
  output logic              irq_o,
  output logic              xfer_ok_o,
  output logic              keep_wait_o
);
  logic cmd_wr, stat_wr, ptr_wr;
  logic start_rise, start_fall;
  logic act, err, irq;
  logic [NUM_DRV-1:0] cap;
  logic [7:0] ptr_rdata, cmd_rdata, stat_rdata;
  logic [SEL_W-1:0] ptr_sel;

  assign cmd_wr  = wr_i && (addr_i == ADDR_W'(OFS_CMD));
  assign stat_wr = wr_i && (addr_i == ADDR_W'(OFS_STAT));
  assign ptr_wr  = wr_i && (addr_i >= ADDR_W'(OFS_PTR));
  assign ptr_sel = SEL_W'(addr_i - ADDR_W'(OFS_PTR));

  bmdma_cmd_reg u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (cmd_wr),
    .start_bit_i  (wdata_i[CMD_START]),
    .dir_bit_i    (wdata_i[CMD_DIR]),
    .start_o      (start_o),
    .dir_o        (dir_to_mem_o),
    .start_rise_o (start_rise),
    .start_fall_o (start_fall)
  );

  bmdma_stat_reg #(.NUM_DRV(NUM_DRV)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (stat_wr),
    .clr_err_i    (wdata_i[ST_ERR]),
    .clr_irq_i    (wdata_i[ST_IRQ]),
    .cap_bits_i   (wdata_i[ST_CAP0 +: NUM_DRV]),
    .start_rise_i (start_rise),
    .start_fall_i (start_fall),
    .eng_stop_i   (eng_stop_i),
    .eng_err_i    (eng_err_i),
    .eng_done_i   (eng_done_i),
    .act_o        (act),
    .err_o        (err),
    .irq_o        (irq),
    .cap_o        (cap)
  );

  bmdma_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_wr),
    .sel_i   (ptr_sel),
    .wdata_i (wdata_i),
    .lock_i  (act),
    .ptr_o   (prd_base_o),
    .rdata_o (ptr_rdata)
  );

  always_comb begin
    cmd_rdata = 8'h00;
    cmd_rdata[CMD_START] = start_o;
    cmd_rdata[CMD_DIR]   = dir_to_mem_o;
    stat_rdata = 8'h00;
    stat_rdata[ST_ACT] = act;
    stat_rdata[ST_ERR] = err;
    stat_rdata[ST_IRQ] = irq;
    stat_rdata[ST_CAP0 +: NUM_DRV] = cap;
  end

  always_comb begin
    if (addr_i >= ADDR_W'(OFS_PTR))          rdata_o = ptr_rdata;
    else if (addr_i == ADDR_W'(OFS_CMD))     rdata_o = cmd_rdata;
    else if (addr_i == ADDR_W'(OFS_STAT))    rdata_o = stat_rdata;
    else                                     rdata_o = 8'h00; // vendor slots
  end

  assign irq_o       = irq;
  assign xfer_ok_o   = irq & ~err & ~act;
  assign keep_wait_o = act & irq;

  AST_START_RISE_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[CMD_START] && !start_o && !eng_stop_i) |=> (act && start_o)); // R3
  AST_OK_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ok_o |-> (irq_o && !keep_wait_o)); // R9
endmodule

// File: tb/tb_bmdma_regs.sv
module tb_bmdma_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ev_stop = 1'b0, ev_err = 1'b0, ev_done = 1'b0;
  logic start, dir, irq, ok, kwait;
  logic [31:0] prd;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef enum int {S_RD, S_START, S_DIR, S_PRD, S_IRQ, S_OK, S_WAIT} sel_e;
  typedef struct {
    sel_e        sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  bmdma_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .eng_stop_i(ev_stop), .eng_err_i(ev_err), .eng_done_i(ev_done),
    .start_o(start), .dir_to_mem_o(dir), .prd_base_o(prd), .irq_o(irq),
    .xfer_ok_o(ok), .keep_wait_o(kwait)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act_v;
      it = sb.pop_front();
      case (it.sel)
        S_RD:    act_v = {24'h0, rdata};
        S_START: act_v = {31'h0, start};
        S_DIR:   act_v = {31'h0, dir};
        S_PRD:   act_v = prd;
        S_IRQ:   act_v = {31'h0, irq};
        S_OK:    act_v = {31'h0, ok};
        default: act_v = {31'h0, kwait};
      endcase
      total++;
      if (act_v !== it.exp) begin
        bad++;
        $display("FAIL %s: got %h expected %h", it.tag, act_v, it.exp);
      end
    end
  end

  task automatic expect_v(input sel_e s, input logic [2:0] a, input logic [31:0] e,
                          input string tag);
    item_t it;
    addr = a;
    it.sel = s; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    expect_v(S_RD, a, {24'h0, e}, tag);
    settle();
  endtask

  task automatic wr_ev(input logic [2:0] a, input logic [7:0] d,
                       input logic s, input logic er, input logic dn, input logic w);
    @(posedge clk); #2;
    addr = a; wdata = d; wr = w; ev_stop = s; ev_err = er; ev_done = dn;
    @(posedge clk); #2;
    wr = 1'b0; ev_stop = 1'b0; ev_err = 1'b0; ev_done = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    wr_ev(a, d, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset values
    rd(3'd0, 8'h00, "R1 cmd reset");
    rd(3'd2, 8'h00, "R1 status reset");
    expect_v(S_PRD, 3'd0, 32'h0, "R1 prd reset");
    expect_v(S_IRQ, 3'd0, 32'h0, "R1 irq reset");
    expect_v(S_OK, 3'd0, 32'h0, "R1 ok reset");
    expect_v(S_WAIT, 3'd0, 32'h0, "R1 wait reset");
    expect_v(S_START, 3'd0, 32'h0, "R1 start reset");
    settle();

    // R7 pointer load, low bits dropped
    wr_reg(3'd4, 8'h13); wr_reg(3'd5, 8'h22); wr_reg(3'd6, 8'h33); wr_reg(3'd7, 8'h44);
    expect_v(S_PRD, 3'd0, 32'h44332210, "R7 prd value");
    settle();
    rd(3'd4, 8'h10, "R7 byte0 readback");
    rd(3'd7, 8'h44, "R7 byte3 readback");

    // R2/R3 start with device-to-memory direction
    wr_reg(3'd0, 8'h09);
    expect_v(S_START, 3'd0, 32'h1, "R2 start_o");
    expect_v(S_DIR, 3'd0, 32'h1, "R2 dir_to_mem_o");
    settle();
    rd(3'd0, 8'h09, "R2 cmd readback");
    rd(3'd2, 8'h01, "R3 active set");
    wr_reg(3'd0, 8'hF7);
    rd(3'd0, 8'h01, "R2 unused cmd bits read 0");
    wr_reg(3'd0, 8'h09);

    // R7 pointer locked while active
    wr_reg(3'd4, 8'hFC);
    expect_v(S_PRD, 3'd0, 32'h44332210, "R7 locked while active");
    settle();

    // R4/R8/R10 completion while active
    wr_ev(3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(3'd2, 8'h05, "R4 done sets irq bit");
    expect_v(S_IRQ, 3'd2, 32'h1, "R8 irq_o follows bit2");
    expect_v(S_WAIT, 3'd2, 32'h1, "R10 keep_wait");
    expect_v(S_OK, 3'd2, 32'h0, "R9 not ok while active");
    settle();

    // R3 stop clears active next edge, R4 irq preserved, R9 ok
    wr_reg(3'd0, 8'h08);
    rd(3'd2, 8'h04, "R3 stop clears active");
    expect_v(S_OK, 3'd2, 32'h1, "R9 ok on 100b");
    expect_v(S_WAIT, 3'd2, 32'h0, "R10 no wait when idle");
    expect_v(S_START, 3'd2, 32'h0, "R2 start cleared");
    settle();

    // R5 write zero keeps, write one clears
    wr_reg(3'd2, 8'h00);
    rd(3'd2, 8'h04, "R5 write 0 keeps irq");
    wr_reg(3'd2, 8'h04);
    rd(3'd2, 8'h00, "R5 write 1 clears irq");
    expect_v(S_IRQ, 3'd2, 32'h0, "R8 irq_o low");
    settle();

    // R4 error event
    wr_ev(3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    rd(3'd2, 8'h02, "R4 err sets bit1");
    expect_v(S_OK, 3'd2, 32'h0, "R9 not ok on error");
    settle();

    // R5 same-cycle: clear both while done arrives
    wr_ev(3'd2, 8'h06, 1'b0, 1'b0, 1'b1, 1'b1);
    rd(3'd2, 8'h04, "R5 done wins over clear, err cleared");
    // R5 same-cycle: clear err while err arrives
    wr_ev(3'd2, 8'h02, 1'b0, 1'b1, 1'b0, 1'b1);
    rd(3'd2, 8'h06, "R5 err wins over clear");

    // R6 capability bits and read-only/zero bits
    wr_reg(3'd2, 8'h60);
    rd(3'd2, 8'h66, "R6 caps set, flags kept");
    wr_reg(3'd2, 8'hFF);
    rd(3'd2, 8'h60, "R6/R3 reserved zero, active read-only");
    wr_reg(3'd2, 8'h20);
    rd(3'd2, 8'h20, "R6 drive1 cap cleared");

    // R3 engine end-of-table clears active, start stays
    wr_reg(3'd0, 8'h01);
    rd(3'd2, 8'h21, "R3 active again");
    wr_ev(3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(3'd2, 8'h20, "R3 eng_stop clears active");
    rd(3'd0, 8'h01, "R3 start bit unaffected by eng_stop");
    // R3 start-clear and done in same cycle
    wr_reg(3'd0, 8'h00); wr_reg(3'd0, 8'h01);
    wr_ev(3'd0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    rd(3'd2, 8'h24, "R3 stop with done same cycle");

    // R7 unlocked again
    wr_reg(3'd4, 8'hAB);
    expect_v(S_PRD, 3'd0, 32'h443322A8, "R7 write after idle");
    settle();

    // R11 vendor slots
    wr_reg(3'd1, 8'hFF); wr_reg(3'd3, 8'hFF);
    rd(3'd1, 8'h00, "R11 offset1 reads 0");
    rd(3'd3, 8'h00, "R11 offset3 reads 0");
    rd(3'd0, 8'h00, "R11 cmd untouched");
    rd(3'd2, 8'h24, "R11 status untouched");
    expect_v(S_PRD, 3'd0, 32'h443322A8, "R11 prd untouched");
    settle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule